// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Guard

This block sits between a memory's write port and its write controller. It watches each write strobe together with its address and data and decides whether that write may reach the array. It keeps one protection flag. When the flag is clear, ordinary writes pass straight through. When it is set, a write passes only if a fixed three-step command prefix comes immediately before it. A separate six-step command sequence clears the flag again.

Each write is presented as a single-cycle strobe with its address and data. In the same cycle the block raises a commit enable if the write is to be stored. The protection flag is visible as an output, and it changes on the clock edge that ends the write which completes a command sequence. Page buffering, write timing and the memory itself sit outside this block; only the commit decision leaves it.

Command words are compared in full: 13-bit address and 8-bit data. Address A is 0x1555 and address B is 0x0AAA. The arming prefix is A/0xAA, B/0x55, A/0xA0. The disarming sequence is A/0xAA, B/0x55, A/0x80, A/0xAA, B/0x55, A/0x20.

Top module: `wprotSeqGuard`

## Requirements
- R1: After reset, protOn is 0 and commitEn is 0.
- R2: commitEn is high only in a cycle where wrStrobe is high.
- R3: While unprotected and not in the middle of a command sequence, a write that does not match the first command step (A/0xAA) raises commitEn in its own strobe cycle.
- R4: The writes that make up a command step (A/0xAA, B/0x55, A/0xA0, A/0x80, A/0x20 when they fall in their place in a sequence) never raise commitEn.
- R5: While protected, a write that is not directly preceded by the complete arming prefix does not raise commitEn.
- R6: Completing the arming prefix A/0xAA, B/0x55, A/0xA0 sets protOn at the clock edge that ends the third write. The very next write raises commitEn, and only that one write.
- R7: Completing the six-step disarming sequence clears protOn at the clock edge that ends the sixth write. protOn is unchanged during the first five steps. Later plain writes raise commitEn.
- R8: A write that breaks a partly matched sequence returns the matcher to idle and is not evaluated as a new first step. It raises commitEn exactly when protOn is 0.
- R9: Command steps match only on an exact 13-bit address and 8-bit data. A one-bit difference in either field counts as a break (R8) or as a plain write.
- R10: Running the arming prefix while already protected leaves protOn at 1.
- R11: The write that follows a completed arming prefix is committed as data even when its address and data equal a command step. It does not start a new sequence.
- R12: protOn changes only at a clock edge that ends a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse marking a write |
| wrAddr | input | 13 | Write address |
| wrData | input | 8 | Write data |
| commitEn | output | 1 | The current write may be stored (same cycle as wrStrobe) |
| protOn | output | 1 | Protection flag |

## Verification
The bench targets several faults.

- **Broken sequences:** it breaks sequences part-way through, both with and without protection. A design that let the breaking byte restart a sequence would swallow a plain write. A design that committed it while protected would leak data into a locked array.
- **Near-miss command words:** it presents words that differ in a single address bit or data bit. A comparator that checks too few bits would then arm or disarm by accident.
- **The write after the prefix:** it checks that exactly one write passes after the prefix, even when that write looks like a command. Wrong arming-state handling would then drop it or leave the window open for further writes.
- **Disarm timing:** it checks the flag after every disarming step. An early clear, or a committed cancel byte, shows up on the first wrong step.

// File: rtl/wprotSeqPkg.sv
package wprotSeqPkg;

  localparam int NUM_STEPS = 5;
  localparam int HIT_AA_A = 0;
  localparam int HIT_55_B = 1;
  localparam int HIT_A0_A = 2;
  localparam int HIT_80_A = 3;
  localparam int HIT_20_A = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_U1    = 3'd1,
    SEQ_U2    = 3'd2,
    SEQ_D3    = 3'd3,
    SEQ_D4    = 3'd4,
    SEQ_D5    = 3'd5,
    SEQ_ARMED = 3'd6
  } seqState_t;

  typedef struct packed {
    logic commit;
    logic setProt;
    logic clrProt;
  } ctrlStrb_t;

endpackage

// File: rtl/wprotSeqMatch.sv
module wprotSeqMatch
  import wprotSeqPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_B = 13'h0AAA,
  parameter logic [DATA_W-1:0] CODE_LEAD = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_SECOND = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_PREDIS = 8'h80,
  parameter logic [DATA_W-1:0] CODE_DISARM = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrb_t         strb,
  output logic [NUM_STEPS-1:0] hit,
  output logic              commitEn,
  output logic              protOn
);

  localparam logic [ADDR_W-1:0] STEP_ADDR [NUM_STEPS] =
    '{ADDR_A, ADDR_B, ADDR_A, ADDR_A, ADDR_A};
  localparam logic [DATA_W-1:0] STEP_DATA [NUM_STEPS] =
    '{CODE_LEAD, CODE_SECOND, CODE_ARM, CODE_PREDIS, CODE_DISARM};

  for (genvar i = 0; i < NUM_STEPS; i++) begin : gStep
    assign hit[i] = wrStrobe && (wrAddr == STEP_ADDR[i]) && (wrData == STEP_DATA[i]);
  end

  logic protQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protQ <= 1'b0;
    end else if (strb.setProt) begin
      protQ <= 1'b1;
    end else if (strb.clrProt) begin
      protQ <= 1'b0;
    end
  end

  assign protOn   = protQ;
  assign commitEn = strb.commit;

endmodule

// File: rtl/wprotSeqCtrl.sv
module wprotSeqCtrl
  import wprotSeqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStrobe,
  input  logic [NUM_STEPS-1:0] hit,
  input  logic                 protOn,
  output ctrlStrb_t            strb
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD       = stateQ;
    strb.commit  = 1'b0;
    strb.setProt = 1'b0;
    strb.clrProt = 1'b0;
    if (wrStrobe) begin
      // default: a break or a plain write falls back to idle
      stateD      = SEQ_IDLE;
      strb.commit = !protOn;
      unique case (stateQ)
        SEQ_IDLE: begin
          if (hit[HIT_AA_A]) begin
            stateD      = SEQ_U1;
            strb.commit = 1'b0;
          end
        end
        SEQ_U1, SEQ_D4: begin
          if (hit[HIT_55_B]) begin
            stateD      = (stateQ == SEQ_U1) ? SEQ_U2 : SEQ_D5;
            strb.commit = 1'b0;
          end
        end
        SEQ_U2: begin
          if (hit[HIT_A0_A]) begin
            stateD       = SEQ_ARMED;
            strb.commit  = 1'b0;
            strb.setProt = 1'b1;
          end else if (hit[HIT_80_A]) begin
            stateD      = SEQ_D3;
            strb.commit = 1'b0;
          end
        end
        SEQ_D3: begin
          if (hit[HIT_AA_A]) begin
            stateD      = SEQ_D4;
            strb.commit = 1'b0;
          end
        end
        SEQ_D5: begin
          if (hit[HIT_20_A]) begin
            strb.commit  = 1'b0;
            strb.clrProt = 1'b1;
          end
        end
        SEQ_ARMED: begin
          strb.commit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

endmodule

// File: rtl/wprotSeqGuard.sv
module wprotSeqGuard
  import wprotSeqPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_B = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              commitEn,
  output logic              protOn
);

  ctrlStrb_t            strb;
  logic [NUM_STEPS-1:0] hit;

  wprotSeqMatch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ADDR_A(ADDR_A),
    .ADDR_B(ADDR_B)
  ) uMatch (
    .clk(clk),
    .rstN(rstN),
    .wrStrobe(wrStrobe),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strb(strb),
    .hit(hit),
    .commitEn(commitEn),
    .protOn(protOn)
  );

  wprotSeqCtrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .wrStrobe(wrStrobe),
    .hit(hit),
    .protOn(protOn),
    .strb(strb)
  );

endmodule

// File: rtl/wprotSeqGuardChk.sv
module wprotSeqGuardChk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 13'h1555
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              commitEn,
  input logic              protOn
);

  AST_RESET_UNPROT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !protOn); // R1

  AST_COMMIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> !commitEn); // R2

  AST_ARM_ON_A0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protOn) |-> ($past(wrAddr) == ADDR_A && $past(wrData) == 8'hA0 && !$past(commitEn))); // R6

  AST_DISARM_ON_20: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protOn) |-> ($past(wrAddr) == ADDR_A && $past(wrData) == 8'h20 && !$past(commitEn))); // R7

  AST_PROT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrStrobe) && $past(rstN)) |-> $stable(protOn)); // R12

endmodule

bind wprotSeqGuard wprotSeqGuardChk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .ADDR_A(ADDR_A)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .wrStrobe(wrStrobe),
  .wrAddr(wrAddr),
  .wrData(wrData),
  .commitEn(commitEn),
  .protOn(protOn)
);

// File: tb/tb_wprotSeqGuard.sv
module tb_wprotSeqGuard;

  localparam logic [12:0] AA = 13'h1555;
  localparam logic [12:0] AB = 13'h0AAA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        commitEn;
  logic        protOn;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expCommit;
    logic  expProt;
    string tag;
  } expItem_t;

  expItem_t scb[$];

  always #2 clk = ~clk;

  wprotSeqGuard dut (
    .clk(clk),
    .rstN(rstN),
    .wrStrobe(wrStrobe),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .commitEn(commitEn),
    .protOn(protOn)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d,
                         input logic expC, input logic expP, input string tag);
    expItem_t it;
    @(negedge clk);
    it.expCommit = expC;
    it.expProt   = expP;
    it.tag       = tag;
    scb.push_back(it);
    wrAddr   = a;
    wrData   = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (wrStrobe) begin
          expItem_t it;
          it = scb.pop_front();
          chk(it.tag, commitEn, it.expCommit, "commitEn");
          @(posedge clk);
          #1;
          chk(it.tag, protOn, it.expProt, "protOn");
        end else begin
          chk("R2", commitEn, 1'b0, "commitEn idle");
        end
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", protOn, 1'b0, "protOn in reset");
    chk("R1", commitEn, 1'b0, "commitEn in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", protOn, 1'b0, "protOn after reset");

    // R3 plain write unprotected
    doWrite(13'h0100, 8'h11, 1'b1, 1'b0, "R3");
    // R6 arm prefix, R4 steps not committed
    doWrite(AA, 8'hAA, 1'b0, 1'b0, "R4");
    doWrite(AB, 8'h55, 1'b0, 1'b0, "R4");
    doWrite(AA, 8'hA0, 1'b0, 1'b1, "R6");
    doWrite(13'h0200, 8'h22, 1'b1, 1'b1, "R6");
    doWrite(13'h0201, 8'h33, 1'b0, 1'b1, "R5");
    // R10 prefix while protected, R11 command-looking data committed
    doWrite(AA, 8'hAA, 1'b0, 1'b1, "R10");
    doWrite(AB, 8'h55, 1'b0, 1'b1, "R10");
    doWrite(AA, 8'hA0, 1'b0, 1'b1, "R10");
    doWrite(AA, 8'hAA, 1'b1, 1'b1, "R11");
    doWrite(AB, 8'h55, 1'b0, 1'b1, "R11");
    // R8 break while protected
    doWrite(AA, 8'hAA, 1'b0, 1'b1, "R8");
    doWrite(AB, 8'h56, 1'b0, 1'b1, "R8");
    doWrite(13'h0300, 8'h01, 1'b0, 1'b1, "R5");
    // R9 one address bit off on third step
    doWrite(AA, 8'hAA, 1'b0, 1'b1, "R9");
    doWrite(AB, 8'h55, 1'b0, 1'b1, "R9");
    doWrite(13'h1554, 8'hA0, 1'b0, 1'b1, "R9");
    doWrite(13'h0301, 8'h02, 1'b0, 1'b1, "R9");
    // R7 disarm
    doWrite(AA, 8'hAA, 1'b0, 1'b1, "R7");
    doWrite(AB, 8'h55, 1'b0, 1'b1, "R7");
    doWrite(AA, 8'h80, 1'b0, 1'b1, "R7");
    doWrite(AA, 8'hAA, 1'b0, 1'b1, "R7");
    doWrite(AB, 8'h55, 1'b0, 1'b1, "R7");
    doWrite(AA, 8'h20, 1'b0, 1'b0, "R7");
    doWrite(13'h0400, 8'h44, 1'b1, 1'b0, "R7");
    // R8 break while unprotected
    doWrite(AA, 8'hAA, 1'b0, 1'b0, "R8");
    doWrite(AB, 8'h55, 1'b0, 1'b0, "R8");
    doWrite(13'h0500, 8'h55, 1'b1, 1'b0, "R8");
    doWrite(AA, 8'hAA, 1'b0, 1'b0, "R8");
    doWrite(AA, 8'hAA, 1'b1, 1'b0, "R8");
    doWrite(AB, 8'h55, 1'b1, 1'b0, "R8");
    // R9 data one bit off
    doWrite(AA, 8'hAB, 1'b1, 1'b0, "R9");
    doWrite(13'h1D55, 8'hAA, 1'b1, 1'b0, "R9");
    // R7 disarm while unprotected stays unprotected
    doWrite(AA, 8'hAA, 1'b0, 1'b0, "R7");
    doWrite(AB, 8'h55, 1'b0, 1'b0, "R7");
    doWrite(AA, 8'h80, 1'b0, 1'b0, "R7");
    doWrite(AA, 8'hAA, 1'b0, 1'b0, "R7");
    doWrite(AB, 8'h55, 1'b0, 1'b0, "R7");
    doWrite(AA, 8'h20, 1'b0, 1'b0, "R7");
    doWrite(13'h0600, 8'h66, 1'b1, 1'b0, "R3");
    // R12 idle cycles keep flag
    repeat (4) @(negedge clk);
    #1;
    chk("R12", protOn, 1'b0, "protOn idle");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule